// File: doc/BRIEF.md
# Latch-Bank Output Expander Sequencer

This block multiplies a small number of driven pins into a large set of output-only lines. It drives one shared data bus of `WIDTH` lines and `BANKS` separate strobe lines. Each strobe line clocks one external `WIDTH`-bit edge-triggered latch, and every latch takes its inputs from the same data bus. The result is `BANKS*WIDTH` expanded outputs. With two 8-bit latches, ten driven lines yield sixteen outputs.

The host changes one expanded output at a time by giving an index and a value through a valid/ready handshake. The block holds a shadow image of all expanded outputs and sets the addressed bit in it. It then puts the entire bank that holds that bit onto the data bus, with bank bit `i` on data line `i`. It waits a programmable setup time and then pulses only that bank's strobe for a programmable width. A one-cycle `done` pulse ends the sequence. The two times are given in nanoseconds, limited to 5000 ns, and turned into clock cycles.

Top module: `latch_bank_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `data_out`, `le_out`, `shadow_out` and `done` are all zero and `req_ready` is 1. An asynchronous reset in the middle of a sequence clears all of these outputs at once.
- R2: An accepted in-range write sets `shadow_out[req_index]` to `req_value` in the cycle after acceptance. The written bit belongs to bank `req_index / WIDTH`, at position `req_index % WIDTH`. No other shadow bit changes.
- R3: In the cycle after acceptance, `data_out[i]` equals `shadow_out[bank*WIDTH + i]` for every `i`, and the new bit is already included. `data_out` holds that value until the next accepted write.
- R4: The target strobe rises S cycles after `data_out` takes its new value. S = ceil(min(setup_ns, 5000) / CLK_PERIOD_NS).
- R5: The strobe stays high for P cycles. P = ceil(min(pulse_ns, 5000) / CLK_PERIOD_NS).
- R6: Only the target bank's strobe `le_out[bank]` pulses. At no time is more than one strobe high.
- R7: A programmed time above 5000 ns is treated as 5000 ns. With a 10 ns clock this gives 500 cycles.
- R8: A time that rounds to zero cycles, including 0 ns, still lasts one cycle.
- R9: `req_ready` is low from acceptance until the sequence ends. A request presented while `req_ready` is low has no effect on `shadow_out`.
- R10: `done` is high for exactly one cycle, in the first cycle in which the strobe is low again. `req_ready` is high in that same cycle.
- R11: An index at or above `BANKS*WIDTH` produces no strobe and leaves `shadow_out` and `data_out` unchanged. `done` is still raised in the cycle after acceptance.
- R12: `line_is_output` reports every expanded line as an output: all bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_index | input | IDX_W | Expanded output index |
| req_value | input | 1 | Value for the addressed output |
| setup_ns | input | NS_W | Data-to-strobe setup time, ns |
| pulse_ns | input | NS_W | Strobe high time, ns |
| req_ready | output | 1 | Block idle, request accepted when valid |
| done | output | 1 | One-cycle end-of-sequence pulse |
| data_out | output | WIDTH | Shared data bus to all latches |
| le_out | output | BANKS | Per-bank strobe lines |
| shadow_out | output | BANKS*WIDTH | Shadow image of all expanded outputs |
| line_is_output | output | BANKS*WIDTH | Direction report, 1 = output |

## Verification
The hardest case to reach is a request that arrives while a sequence is still running. The host interface normally waits for `req_ready`, so such a request never shows up on its own. The bench starts a write with a long setup time and then, on the very next cycle, drives a competing request to a different index. It removes that request before the block goes idle and confirms that the competing bit never reaches the shadow image. The bench also covers the clamp boundary with a 9000 ns and a 5000 ns interval, and it covers an index exactly equal to the output count.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lbs_ns_to_cyc.sv
// Converts a nanosecond interval into whole clock cycles.
// Clamps to the cap, rounds up, and never returns zero.
module lbs_ns_to_cyc #(
  parameter int NS_W      = 16,
  parameter int PERIOD_NS = 10,
  parameter int CAP_NS    = 5000,
  parameter int CNT_W     = 9
) (
  input  logic [NS_W-1:0]  ns_in,
  output logic [CNT_W-1:0] cyc_out
);
  localparam logic [31:0] CAP32 = 32'(CAP_NS);
  localparam logic [31:0] PER32 = 32'(PERIOD_NS);

  logic [31:0] ns_ext;
  logic [31:0] ns_clamped;
  logic [31:0] rounded;

  always_comb begin
    ns_ext     = 32'(ns_in);
    ns_clamped = (ns_ext > CAP32) ? CAP32 : ns_ext;
    rounded    = (ns_clamped + PER32 - 32'd1) / PER32;
    cyc_out    = (rounded == 32'd0) ? CNT_W'(1) : rounded[CNT_W-1:0];
  end
endmodule

// File: rtl/lbs_shadow.sv
// Shadow image of every expanded output, plus a selector that returns
// one bank of the image as it will be after the pending write.
module lbs_shadow #(
  parameter int BANKS  = 2,
  parameter int WIDTH  = 8,
  parameter int IDX_W  = 5,
  parameter int BANK_W = 1,
  localparam int TOTAL = BANKS * WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_bit,
  input  logic              wr_value,
  input  logic [BANK_W-1:0] rd_bank,
  output logic [TOTAL-1:0]  shadow_q,
  output logic [WIDTH-1:0]  bank_word
);
  logic [TOTAL-1:0] shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    for (int k = 0; k < TOTAL; k++) begin
      if (wr_en && (wr_bit == IDX_W'(k))) shadow_d[k] = wr_value;
    end
  end

  always_comb begin
    bank_word = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (rd_bank == BANK_W'(b)) bank_word = shadow_d[b*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (wr_en) shadow_q <= shadow_d;
  end

  // R9 R11: the image only moves on an accepted in-range write
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow_q));
endmodule

// File: rtl/lbs_strobe_dec.sv
// Bank number to one-hot strobe pattern.
module lbs_strobe_dec #(
  parameter int BANKS  = 2,
  parameter int BANK_W = 1
) (
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  onehot
);
  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    assign onehot[b] = (bank == BANK_W'(b));
  end
endmodule

// File: rtl/latch_bank_seq.sv
module latch_bank_seq
  import lbs_pkg::*;
#(
  parameter int  BANKS         = 2,
  parameter int  WIDTH         = 8,
  parameter int  NS_W          = 16,
  parameter int  CLK_PERIOD_NS = 10,
  parameter int  CAP_NS        = 5000,
  localparam int TOTAL         = BANKS * WIDTH,
  localparam int IDX_W         = $clog2(TOTAL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic             req_value,
  input  logic [NS_W-1:0]  setup_ns,
  input  logic [NS_W-1:0]  pulse_ns,
  output logic             req_ready,
  output logic             done,
  output logic [WIDTH-1:0] data_out,
  output logic [BANKS-1:0] le_out,
  output logic [TOTAL-1:0] shadow_out,
  output logic [TOTAL-1:0] line_is_output
);
  localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int CAP_CYC = (CAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CNT_W   = $clog2(CAP_CYC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // request decode
  logic              accept, in_range, wr_en;
  logic [IDX_W-1:0]  bank_full;
  logic [BANK_W-1:0] req_bank;
  logic [WIDTH-1:0]  bank_word;
  logic [CNT_W-1:0]  setup_cyc, pulse_cyc;
  logic [BANKS-1:0]  bank_onehot;

  // sequencer state
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  pulse_q, pulse_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [WIDTH-1:0]  data_q, data_d;
  logic [BANKS-1:0]  le_q, le_d;
  logic              done_q, done_d;
  logic              seq_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign in_range  = (req_index < IDX_W'(TOTAL));
  assign wr_en     = accept & in_range;
  assign bank_full = req_index / IDX_W'(WIDTH);
  assign req_bank  = bank_full[BANK_W-1:0];

  lbs_ns_to_cyc #(
    .NS_W(NS_W), .PERIOD_NS(CLK_PERIOD_NS), .CAP_NS(CAP_NS), .CNT_W(CNT_W)
  ) u_setup_conv (
    .ns_in(setup_ns), .cyc_out(setup_cyc)
  );

  lbs_ns_to_cyc #(
    .NS_W(NS_W), .PERIOD_NS(CLK_PERIOD_NS), .CAP_NS(CAP_NS), .CNT_W(CNT_W)
  ) u_pulse_conv (
    .ns_in(pulse_ns), .cyc_out(pulse_cyc)
  );

  lbs_shadow #(
    .BANKS(BANKS), .WIDTH(WIDTH), .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_bit(req_index),
    .wr_value(req_value), .rd_bank(req_bank),
    .shadow_q(shadow_out), .bank_word(bank_word)
  );

  lbs_strobe_dec #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dec (
    .bank(bank_q), .onehot(bank_onehot)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    bank_d  = bank_q;
    data_d  = data_q;
    le_d    = le_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (in_range) begin
            state_d = ST_SETUP;
            cnt_d   = setup_cyc - CNT_W'(1);
            pulse_d = pulse_cyc;
            bank_d  = req_bank;
            data_d  = bank_word;
          end else begin
            done_d  = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_PULSE;
          cnt_d   = pulse_q - CNT_W'(1);
          le_d    = bank_onehot;
        end else begin
          cnt_d   = cnt_q - CNT_W'(1);
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          le_d    = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d   = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign seq_en = accept | (state_q != ST_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= '0;
      bank_q  <= '0;
      data_q  <= '0;
      le_q    <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      bank_q  <= bank_d;
      data_q  <= data_d;
      le_q    <= le_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign done           = done_q;
  assign data_out       = data_q;
  assign le_out         = le_q;
  assign line_is_output = '1;

  // R6
  le_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(le_q));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_PULSE) |-> $stable(data_q));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);
  // R10
  le_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(|le_q) |-> (done_q && req_ready));
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|le_q) |-> !req_ready);
endmodule

// File: tb/latch_bank_seq_bench.sv
module latch_bank_seq_bench;
  localparam int CLK_NS = 10;
  localparam int W      = 8;
  localparam int NB     = 2;
  localparam int TOT    = NB * W;
  localparam int IW     = 5;
  localparam int NV     = 8;

  localparam int V_IDX [NV] = '{3, 12, 15, 0, 3, 8, 7, 12};
  localparam int V_VAL [NV] = '{1, 1, 1, 1, 0, 1, 1, 0};
  localparam int V_SNS [NV] = '{20, 0, 15, 9000, 10, 1, 40, 10};
  localparam int V_PNS [NV] = '{30, 0, 11, 10, 5000, 1, 20, 10};
  localparam int V_ES  [NV] = '{2, 1, 2, 500, 1, 1, 4, 1};
  localparam int V_EP  [NV] = '{3, 1, 2, 1, 500, 1, 2, 1};

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [IW-1:0] req_index;
  logic req_value;
  logic [15:0] setup_ns, pulse_ns;
  logic req_ready, done;
  logic [W-1:0] data_out;
  logic [NB-1:0] le_out;
  logic [TOT-1:0] shadow_out, line_is_output;

  int checks = 0;
  int fails  = 0;
  logic [TOT-1:0] model;

  always #(CLK_NS/2) clk = ~clk;

  latch_bank_seq u_latch_bank_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_value(req_value), .setup_ns(setup_ns), .pulse_ns(pulse_ns),
    .req_ready(req_ready), .done(done), .data_out(data_out), .le_out(le_out),
    .shadow_out(shadow_out), .line_is_output(line_is_output)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!req_ready && guard < 2000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic run_write(input int idx, input int val, input int sns,
                           input int pns, input int es, input int ep);
    int bank;
    int cnt;
    logic [NB-1:0] exp_le;
    wait_ready();
    req_valid = 1'b1; req_index = IW'(idx); req_value = val[0];
    setup_ns = 16'(sns); pulse_ns = 16'(pns);
    @(negedge clk);
    req_valid = 1'b0;
    model[idx] = val[0];
    bank = idx / W;
    exp_le = NB'(1) << bank;
    chk(shadow_out == model, "R2 shadow", 32'(shadow_out), 32'(model));
    chk(data_out == model[bank*W +: W], "R3 bank on data bus",
        32'(data_out), 32'(model[bank*W +: W]));
    chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
    cnt = 0;
    while (le_out == '0 && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == es, "R4/R7/R8 setup cycles", 32'(cnt), 32'(es));
    chk(le_out == exp_le, "R6 target strobe", 32'(le_out), 32'(exp_le));
    cnt = 0;
    while (le_out != '0 && cnt < 2000) begin
      if (le_out != exp_le) chk(1'b0, "R6 strobe", 32'(le_out), 32'(exp_le));
      if (data_out != model[bank*W +: W])
        chk(1'b0, "R3 hold", 32'(data_out), 32'(model[bank*W +: W]));
      cnt++;
      @(negedge clk);
    end
    chk(cnt == ep, "R5/R7/R8 pulse cycles", 32'(cnt), 32'(ep));
    chk(done == 1'b1 && req_ready == 1'b1, "R10 done at strobe fall",
        {30'd0, done, req_ready}, 32'd3);
  endtask

  task automatic bad_index(input int idx);
    wait_ready();
    req_valid = 1'b1; req_index = IW'(idx); req_value = 1'b1;
    setup_ns = 16'd10; pulse_ns = 16'd10;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R11 done on bad index", 32'(done), 1);
    for (int k = 0; k < 4; k++) begin
      chk(le_out == '0 && shadow_out == model, "R11 no strobe, no change",
          {le_out, 14'd0, shadow_out}, {2'd0, 14'd0, model});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int guard;
    model = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_index = '0; req_value = 1'b0;
    setup_ns = '0; pulse_ns = '0;
    repeat (3) @(negedge clk);
    // R1 values under reset
    chk(data_out == '0 && le_out == '0 && shadow_out == '0 && done == 1'b0,
        "R1 reset outputs", {data_out, le_out, shadow_out, 5'd0, done},
        32'd0);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_is_output == '1, "R12 all outputs", 32'(line_is_output), 32'hffff);

    for (int v = 0; v < NV; v++)
      run_write(V_IDX[v], V_VAL[v], V_SNS[v], V_PNS[v], V_ES[v], V_EP[v]);

    // R9: competing request while busy has no effect
    wait_ready();
    req_valid = 1'b1; req_index = IW'(1); req_value = 1'b1;
    setup_ns = 16'd100; pulse_ns = 16'd10;
    @(negedge clk);
    model[1] = 1'b1;
    req_index = IW'(2); req_value = 1'b1;
    chk(req_ready == 1'b0, "R9 not ready while busy", 32'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(shadow_out == model, "R9 busy request ignored", 32'(shadow_out),
        32'(model));
    guard = 0;
    while (!done && guard < 2000) begin
      guard++;
      @(negedge clk);
    end
    chk(shadow_out == model, "R9 shadow after sequence", 32'(shadow_out),
        32'(model));
    @(negedge clk);
    chk(done == 1'b0, "R10 done lasts one cycle", 32'(done), 0);

    // R11: indices at and above the output count
    bad_index(16);
    bad_index(20);

    // R1: asynchronous reset in mid sequence
    wait_ready();
    req_valid = 1'b1; req_index = IW'(9); req_value = 1'b1;
    setup_ns = 16'd200; pulse_ns = 16'd10;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(data_out == '0 && le_out == '0 && shadow_out == '0,
        "R1 mid-sequence reset", {data_out, le_out, shadow_out, 6'd0}, 32'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    repeat (3) @(negedge clk);
    run_write(14, 1, 10, 10, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule